// File: doc/BRIEF.md
# SPI Bit-Clock Sequencer

This block paces an 8-bit SPI master transfer. It takes ticks from one of two sources: the bus phase signal or a free external clock. A select input picks the source. It can slow those ticks down with a programmable divider. From them it runs a state counter, and it derives the serial clock from that counter. Register decoding and the shift datapath sit outside the block. They use the state number and the per-state advance strobe to decide when to shift and when to sample.

Both source signals are asynchronous to the system clock. Each is brought in through a synchronizer and turned into a one-cycle tick: a falling edge of the phase signal, or a rising edge of the external clock. A transfer runs while the busy input is high. It walks the counter from 0 up to the final state, which is twice the bit count. On reaching that state the block emits a done pulse. The surrounding logic then lowers busy, raises its interrupt and sets its finished flag.

Top module: `spi_bitclk_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, stateNum is 0, advance and done are 0, and sclk equals cpol.
- R2: With extSel at 0, each falling edge of phaseIn is a source tick and extClkIn is ignored. With extSel at 1, each rising edge of extClkIn is a source tick and phaseIn is ignored.
- R3: With divisor 0 the divider is bypassed, and stateNum increases by one on every source tick.
- R4: With divisor N (1 to 255), stateNum increases by one on every (N+1)-th source tick after busy rises.
- R5: While busy is 0 the divider count and stateNum are held at 0. A partly counted divider interval is lost when busy drops.
- R6: stateNum counts 0, 1, 2 and so on up to 16. It stays at 16, with no further advance, until busy goes low.
- R7: done is a one-cycle pulse that appears together with the first cycle in which stateNum is 16.
- R8: sclk equals bit 0 of stateNum XOR cpol, so sclk rests at the cpol level while idle.
- R9: advance is high for exactly one cycle each time stateNum increments. That is the first cycle in which the new value is visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| phaseIn | input | 1 | Bus phase signal; a falling edge is a tick |
| extClkIn | input | 1 | External clock; a rising edge is a tick |
| extSel | input | 1 | Tick source select: 0 phase, 1 external |
| busy | input | 1 | Transfer active; low clears divider and state |
| divisor | input | 8 | Divider value; 0 bypasses the divider |
| cpol | input | 1 | Serial clock idle level |
| sclk | output | 1 | Serial clock |
| stateNum | output | 5 | Current state, 0 idle to 16 end |
| advance | output | 1 | One-cycle strobe with each new state |
| done | output | 1 | One-cycle pulse on reaching state 16 |

## Verification
The assertions assume that extSel, divisor and cpol do not change while busy is high. They also assume that each level of phaseIn and extClkIn lasts at least two system clocks, so that no edge is lost in the synchronizer. The stimulus holds every source level for four clocks. It changes the select, divisor and polarity only while busy is low. It lowers busy only between runs, or deliberately in the middle of a divider interval to test that the interval is discarded.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  // Strobes from the control side to the state datapath
  typedef struct packed {
    logic tick;   // selected source tick this cycle
    logic step;   // divider interval complete: advance the state
    logic clear;  // hold state at zero
  } seqStrobe_t;
endpackage

// File: rtl/spiSeqSync.sv
module spiSeqSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spiSeqCtrl.sv
module spiSeqCtrl
  import spi_seq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseIn,
  input  logic             extClkIn,
  input  logic             extSel,
  input  logic             busy,
  input  logic [DIV_W-1:0] divisor,
  output seqStrobe_t       strb
);
  logic phaseSync, extSync;
  logic phasePrev, extPrev;
  logic phaseFall, extRise, srcTick;
  logic [DIV_W-1:0] divCnt;
  logic divHit;

  spiSeqSync #(.STAGES(SYNC_STAGES)) u_phSync (
    .clk(clk), .rstN(rstN), .din(phaseIn), .dout(phaseSync));
  spiSeqSync #(.STAGES(SYNC_STAGES)) u_exSync (
    .clk(clk), .rstN(rstN), .din(extClkIn), .dout(extSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phasePrev <= 1'b0;
      extPrev   <= 1'b0;
    end else begin
      phasePrev <= phaseSync;
      extPrev   <= extSync;
    end
  end

  assign phaseFall = phasePrev & ~phaseSync;
  assign extRise   = extSync & ~extPrev;
  assign srcTick   = extSel ? extRise : phaseFall;

  // Divider: with divisor 0, divCnt stays 0 and matches on every tick
  assign divHit = (divCnt == divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divCnt <= '0;
    else if (!busy)         divCnt <= '0;
    else if (srcTick) begin
      if (divHit)           divCnt <= '0;
      else                  divCnt <= divCnt + 1'b1;
    end
  end

  assign strb.tick  = srcTick;
  assign strb.step  = busy & srcTick & divHit;
  assign strb.clear = ~busy;

  p_div_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> (divCnt == '0));
  p_bypass_every_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && srcTick && divisor == '0) |-> strb.step);
  p_ext_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!extSel && extRise && !phaseFall) |-> !strb.tick);
endmodule

// File: rtl/spiSeqPath.sv
module spiSeqPath
  import spi_seq_pkg::*;
#(
  parameter int LAST_STATE = 16,
  parameter int ST_W       = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strb,
  input  logic            cpol,
  output logic [ST_W-1:0] stateNum,
  output logic            advance,
  output logic            done,
  output logic            sclk
);
  localparam logic [ST_W-1:0] LAST   = ST_W'(LAST_STATE);
  localparam logic [ST_W-1:0] PENULT = ST_W'(LAST_STATE - 1);

  logic atEnd, bump;

  assign atEnd = (stateNum == LAST);
  assign bump  = strb.step & ~atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateNum <= '0;
      advance  <= 1'b0;
      done     <= 1'b0;
    end else if (strb.clear) begin
      stateNum <= '0;
      advance  <= 1'b0;
      done     <= 1'b0;
    end else begin
      advance <= bump;
      done    <= bump & (stateNum == PENULT);
      if (bump) stateNum <= stateNum + 1'b1;
    end
  end

  assign sclk = stateNum[0] ^ cpol;

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (stateNum == '0));
  p_step_by_one_r9: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> (stateNum == ST_W'($past(stateNum) + 1'b1)));
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (advance && stateNum == LAST));
  p_state_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    stateNum <= LAST);
  p_hold_at_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (atEnd && !strb.clear) |=> (atEnd && !advance));
  p_sclk_rest_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateNum == '0) |-> (sclk == cpol));
endmodule

// File: rtl/spi_bitclk_seq.sv
module spi_bitclk_seq
  import spi_seq_pkg::*;
#(
  parameter int BIT_COUNT   = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LAST_STATE = 2 * BIT_COUNT,
  localparam int ST_W       = $clog2(LAST_STATE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseIn,
  input  logic             extClkIn,
  input  logic             extSel,
  input  logic             busy,
  input  logic [DIV_W-1:0] divisor,
  input  logic             cpol,
  output logic             sclk,
  output logic [ST_W-1:0]  stateNum,
  output logic             advance,
  output logic             done
);
  seqStrobe_t strb;

  spiSeqCtrl #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .extClkIn(extClkIn),
    .extSel(extSel), .busy(busy), .divisor(divisor), .strb(strb));

  spiSeqPath #(.LAST_STATE(LAST_STATE), .ST_W(ST_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .cpol(cpol),
    .stateNum(stateNum), .advance(advance), .done(done), .sclk(sclk));

  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (stateNum == '0 && !advance && !done));
endmodule

// File: tb/sim_spi_bitclk_seq.sv
module sim_spi_bitclk_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseIn = 1'b0, extClkIn = 1'b0, extSel = 1'b0, busy = 1'b0, cpol = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic sclk, advance, done;
  logic [4:0] stateNum;

  int checks = 0, fails = 0;
  int expQ[$];
  int bCnt = 0, bState = 0;

  always #5 clk = ~clk;

  spi_bitclk_seq u0 (
    .clk(clk), .rstN(rstN), .phaseIn(phaseIn), .extClkIn(extClkIn),
    .extSel(extSel), .busy(busy), .divisor(divisor), .cpol(cpol),
    .sclk(sclk), .stateNum(stateNum), .advance(advance), .done(done));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Expected-state model per R3/R4/R6: called on each accepted tick
  task automatic modelTick();
    if (!busy) return;
    if (bCnt == int'(divisor)) begin
      bCnt = 0;
      if (bState < 16) begin
        bState++;
        expQ.push_back(bState);
      end
    end else bCnt++;
  endtask

  // One full period on a source; live=1 when it is the selected one (R2)
  task automatic pulsePhase(input bit live);
    phaseIn = 1'b1; waitN(4);
    phaseIn = 1'b0; if (live) modelTick(); waitN(4);
  endtask

  task automatic pulseExt(input bit live);
    extClkIn = 1'b1; if (live) modelTick(); waitN(4);
    extClkIn = 1'b0; waitN(4);
  endtask

  task automatic setBusy(input logic v);
    busy = v;
    if (!v) begin bCnt = 0; bState = 0; end
    waitN(4);
  endtask

  task automatic drainCheck(input string req);
    check({req, " pending advances"}, expQ.size(), 0);
    expQ.delete();
  endtask

  // Monitor: pops an expected state for each advance strobe
  always @(negedge clk) begin
    if (rstN) begin
      if (advance) begin
        if (expQ.size() == 0) check("R9 unexpected advance", 1, 0);
        else begin
          automatic int e = expQ.pop_front();
          check("R9 state on advance", int'(stateNum), e);
          check("R7 done with state", int'(done), (e == 16) ? 1 : 0);
          check("R8 sclk", int'(sclk), (e % 2) ^ int'(cpol));
        end
      end else if (done) check("R7 done without advance", 1, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    waitN(3);
    check("R1 state in reset", int'(stateNum), 0);
    check("R1 sclk in reset", int'(sclk), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 state after reset", int'(stateNum), 0);
    check("R1 advance after reset", int'(advance), 0);
    check("R1 done after reset", int'(done), 0);

    // Full transfer, phase source, bypass divider
    setBusy(1'b1);
    for (int i = 0; i < 18; i++) pulsePhase(1'b1);
    check("R6 held at end", int'(stateNum), 16);
    drainCheck("R3");
    setBusy(1'b0);
    check("R5 state cleared by busy low", int'(stateNum), 0);
    check("R8 idle sclk cpol=0", int'(sclk), 0);

    // External source ignored while phase selected
    setBusy(1'b1);
    for (int i = 0; i < 3; i++) pulseExt(1'b0);
    check("R2 ext ignored", int'(stateNum), 0);
    drainCheck("R2");
    setBusy(1'b0);

    // External source, divisor 1, cpol 1; phase ignored
    extSel = 1'b1; divisor = 8'd1; cpol = 1'b1;
    waitN(2);
    check("R8 idle sclk cpol=1", int'(sclk), 1);
    setBusy(1'b1);
    for (int i = 0; i < 3; i++) pulsePhase(1'b0);
    check("R2 phase ignored", int'(stateNum), 0);
    for (int i = 0; i < 10; i++) pulseExt(1'b1);
    check("R4 divide by two", int'(stateNum), 5);
    drainCheck("R4");
    setBusy(1'b0);

    // Divider interval discarded when busy drops
    divisor = 8'd3; cpol = 1'b0;
    setBusy(1'b1);
    pulseExt(1'b1); pulseExt(1'b1);
    setBusy(1'b0);
    setBusy(1'b1);
    for (int i = 0; i < 3; i++) pulseExt(1'b1);
    check("R5 partial interval lost", int'(stateNum), 0);
    pulseExt(1'b1);
    check("R4 divisor 3 step", int'(stateNum), 1);
    drainCheck("R5");
    setBusy(1'b0);

    // Largest divisor
    divisor = 8'd255; extSel = 1'b0;
    setBusy(1'b1);
    for (int i = 0; i < 255; i++) pulsePhase(1'b1);
    check("R4 divisor 255 before", int'(stateNum), 0);
    pulsePhase(1'b1);
    check("R4 divisor 255 after", int'(stateNum), 1);
    drainCheck("R4 max");
    setBusy(1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule